// File: doc/BRIEF.md
# HART Frame Transmit Sequencer

This block sits between a host that supplies frame bytes and an FSK modulator that turns a serial NRZ stream into tones. A single-cycle start request raises the carrier request line. The block then lets the line settle at mark for a fixed lead-in. Next it shifts out a run of 0xFF preamble characters, followed by the host's payload bytes. Each character is eleven bits long at 1200 bit/s. After the last stop bit the carrier stays on for a guard period, and then the carrier request drops.

The host hands over bytes on a valid/ready stream. A `last` flag marks the final byte of the frame. Ready goes high only in the payload phase and only at a character boundary. If the host has nothing to offer at that point, the line idles at mark and the carrier stays on until a byte arrives.

The state machine runs IDLE → CARRIER_ON → PREAMBLE → PAYLOAD → TAIL → IDLE. The transitions are:
- IDLE goes to CARRIER_ON on a start request.
- CARRIER_ON goes to PREAMBLE after two bit times, loading the first preamble character.
- PREAMBLE goes to PAYLOAD when the stop bit of the fifth preamble character completes.
- PAYLOAD goes to TAIL when the stop bit of the byte flagged last completes.
- TAIL goes to IDLE after one bit time.

Top module: `hart_tx_seq`

## Requirements
- R1: While reset is held and immediately after it, the carrier request is low, the serial line is at mark (1) and ready is low.
- R2: A start request sampled while idle raises the carrier request on that same clock edge, with the line at mark. Without a start request an idle block keeps the carrier low, and the line is never low while the carrier is off.
- R3: The falling edge of the first start bit comes exactly two bit times (2 × 384 = 768 clocks) after the carrier request rises. The line is at mark during that wait.
- R4: Exactly five characters carrying 0xFF go out before the first payload byte.
- R5: Every character has the following format:
  - a start bit of 0;
  - eight data bits, least significant bit first;
  - an odd parity bit, so the data plus parity hold an odd number of ones;
  - a stop bit of 1.
  Each bit lasts 384 clocks.
- R6: Ready goes high only in the payload phase at a character boundary, while the carrier is on and the line is at mark. Every accepted byte is sent exactly once, in order of acceptance.
- R7: If no byte is offered at a payload character boundary, the line stays at mark and the carrier stays on for as long as the host waits.
- R8: After the stop bit of the byte flagged last, the carrier request stays high for exactly one more bit time (384 clocks) with the line at mark, and then it falls.
- R9: A start request during a frame in progress is ignored. The frame continues with its preamble count and payload unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, nominally 460.8 kHz |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle frame start request |
| tx_data_i | input | 8 | Payload byte from host |
| tx_valid_i | input | 1 | Host byte valid |
| tx_last_i | input | 1 | Byte is the final one of the frame |
| tx_ready_o | output | 1 | Block accepts a byte on this cycle |
| txd_o | output | 1 | NRZ serial data to modulator, idle 1 |
| carrier_req_o | output | 1 | Carrier request, active high |

## Verification
The bench decodes the serial line at mid-bit and compares each character against a scoreboard of expected bytes. It measures the exact gap from carrier rise to the first start edge, so a design that shifts early, or loses a bit of lead-in, shows a wrong count. It checks the tail from the end of the last stop bit to the carrier fall, which catches a design that drops the carrier together with the stop bit. One frame holds back its second byte for a long gap, so a design that closes the frame or lets the line float low would be caught. That frame also carries a stray start pulse in the middle of the preamble; a design that restarts would send more than five 0xFF characters and fail the character count.

// File: rtl/hart_tx_pkg.sv
package hart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CARRIER_ON,
        ST_PREAMBLE,
        ST_PAYLOAD,
        ST_TAIL
    } seq_state_t;

    localparam int CHAR_BITS = 11;
    localparam logic [7:0] PREAMBLE_BYTE = 8'hFF;

    // start(0), data LSB first, odd parity, stop(1); bit 0 leaves first
    function automatic logic [CHAR_BITS-1:0] build_char(input logic [7:0] d);
        return {1'b1, ~(^d), d, 1'b0};
    endfunction

endpackage

// File: rtl/hart_bit_timer.sv
module hart_bit_timer #(
    parameter int CLK_PER_BIT = 384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hart_char_shifter.sv
module hart_char_shifter
    import hart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] data_i,
    input  logic       tick_i,
    output logic       line_o,
    output logic       busy_o,
    output logic       done_o
);
    localparam logic [3:0] LAST_BIT = 4'(CHAR_BITS - 1);

    logic [CHAR_BITS-1:0] sh_q;
    logic [3:0]           bit_q;
    logic                 busy_q;

    assign busy_o = busy_q;
    assign done_o = busy_q && tick_i && (bit_q == LAST_BIT);
    assign line_o = busy_q ? sh_q[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '1;
            bit_q  <= '0;
            busy_q <= 1'b0;
        end else if (load_i) begin
            sh_q   <= build_char(data_i);
            bit_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q && tick_i) begin
            if (bit_q == LAST_BIT) begin
                busy_q <= 1'b0;
            end else begin
                sh_q  <= {1'b1, sh_q[CHAR_BITS-1:1]};
                bit_q <= bit_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hart_tx_seq.sv
module hart_tx_seq
    import hart_tx_pkg::*;
#(
    parameter int CLK_PER_BIT   = 384,
    parameter int LEAD_BITS     = 2,
    parameter int PREAMBLE_LEN  = 5,
    parameter int TAIL_BITS     = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] tx_data_i,
    input  logic       tx_valid_i,
    input  logic       tx_last_i,
    output logic       tx_ready_o,
    output logic       txd_o,
    output logic       carrier_req_o
);
    localparam int MAXC = (PREAMBLE_LEN > LEAD_BITS)
                        ? ((PREAMBLE_LEN > TAIL_BITS) ? PREAMBLE_LEN : TAIL_BITS)
                        : ((LEAD_BITS > TAIL_BITS) ? LEAD_BITS : TAIL_BITS);
    localparam int PW = $clog2(MAXC + 1);
    localparam logic [PW-1:0] LEAD_END = PW'(LEAD_BITS - 1);
    localparam logic [PW-1:0] PRE_END  = PW'(PREAMBLE_LEN - 1);
    localparam logic [PW-1:0] TAIL_END = PW'(TAIL_BITS - 1);

    seq_state_t state_q, state_d;
    logic [PW-1:0] phase_q;
    logic          last_q;
    logic          tick, busy, done, line;
    logic          load, accept, ready;
    logic [7:0]    load_data;

    hart_bit_timer #(.CLK_PER_BIT(CLK_PER_BIT)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i ((state_q == ST_IDLE) || load),
        .tick_o    (tick)
    );

    hart_char_shifter shifter_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .data_i (load_data),
        .tick_i (tick),
        .line_o (line),
        .busy_o (busy),
        .done_o (done)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start_i) state_d = ST_CARRIER_ON;
            ST_CARRIER_ON: if (tick && phase_q == LEAD_END) state_d = ST_PREAMBLE;
            ST_PREAMBLE:   if (done && phase_q == PRE_END) state_d = ST_PAYLOAD;
            ST_PAYLOAD:    if (done && last_q) state_d = ST_TAIL;
            ST_TAIL:       if (tick && phase_q == TAIL_END) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // state register and phase bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                phase_q <= '0;
            end else if (((state_q == ST_CARRIER_ON) || (state_q == ST_TAIL)) && tick) begin
                phase_q <= phase_q + 1'b1;
            end else if ((state_q == ST_PREAMBLE) && done) begin
                phase_q <= phase_q + 1'b1;
            end
            if (state_q == ST_IDLE) begin
                last_q <= 1'b0;
            end else if (accept && tx_last_i) begin
                last_q <= 1'b1;
            end
        end
    end

    // outputs and shifter control
    always_comb begin
        ready     = (state_q == ST_PAYLOAD) && !last_q && (!busy || done);
        accept    = ready && tx_valid_i;
        load      = 1'b0;
        load_data = PREAMBLE_BYTE;
        unique case (state_q)
            ST_CARRIER_ON: load = tick && (phase_q == LEAD_END);
            ST_PREAMBLE:   load = done && (phase_q != PRE_END);
            ST_PAYLOAD: begin
                load      = accept;
                load_data = tx_data_i;
            end
            default: load = 1'b0;
        endcase
        tx_ready_o    = ready;
        carrier_req_o = (state_q != ST_IDLE);
        txd_o         = line;
    end
endmodule

// File: rtl/hart_tx_seq_chk.sv
module hart_tx_seq_chk #(
    parameter int CLK_PER_BIT = 384
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic tx_ready_o,
    input logic txd_o,
    input logic carrier_req_o
);
    int mark_run;

    always_ff @(posedge clk) begin
        if (!rst_n || !txd_o) begin
            mark_run <= 0;
        end else if (mark_run < CLK_PER_BIT) begin
            mark_run <= mark_run + 1;
        end
    end

    assert_mark_without_carrier_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_req_o |-> txd_o);

    assert_carrier_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!carrier_req_o && start_i) |=> carrier_req_o);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!carrier_req_o && !start_i) |=> !carrier_req_o);

    assert_rise_at_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier_req_o) |-> txd_o);

    assert_ready_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> (carrier_req_o && txd_o));

    assert_tail_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carrier_req_o) |-> (mark_run >= CLK_PER_BIT));
endmodule

bind hart_tx_seq hart_tx_seq_chk #(.CLK_PER_BIT(CLK_PER_BIT)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .tx_ready_o    (tx_ready_o),
    .txd_o         (txd_o),
    .carrier_req_o (carrier_req_o)
);

// File: tb/hart_tx_seq_tb_top.sv
module hart_tx_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BIT  = 384;
    localparam int PRE  = 5;
    localparam int LEAD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] tx_data_i = '0;
    logic       tx_valid_i = 1'b0;
    logic       tx_last_i = 1'b0;
    logic       tx_ready_o, txd_o, carrier_req_o;

    hart_tx_seq dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .tx_data_i     (tx_data_i),
        .tx_valid_i    (tx_valid_i),
        .tx_last_i     (tx_last_i),
        .tx_ready_o    (tx_ready_o),
        .txd_o         (txd_o),
        .carrier_req_o (carrier_req_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0;
    logic [7:0] exp_q[$];
    int frame_chars = 0, exp_chars = 0, c_rise = 0, last_end = 0, ready_bad = 0;
    logic car_d = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // carrier edge monitor: lead reference, tail length, char count, ready hygiene
    always @(negedge clk) begin
        if (rst_n) begin
            if (carrier_req_o && !car_d) begin
                c_rise = cyc;
                frame_chars = 0;
            end
            if (!carrier_req_o && car_d) begin
                chk(cyc - last_end == BIT, "R8 tail length", cyc - last_end, BIT);
                chk(frame_chars == exp_chars, "R4 character count", frame_chars, exp_chars);
            end
            if (tx_ready_o && !(carrier_req_o && txd_o)) ready_bad++;
        end
        car_d = carrier_req_o;
    end

    // serial decoder and scoreboard consumer
    initial begin
        int cs;
        logic [10:0] ch;
        logic [7:0] e;
        forever begin
            @(negedge clk);
            if (rst_n && carrier_req_o && !txd_o) begin
                cs = cyc;
                for (int k = 0; k < 11; k++) begin
                    repeat ((k == 0) ? BIT/2 : BIT) @(negedge clk);
                    ch[k] = txd_o;
                end
                if (frame_chars == 0)
                    chk(cs - c_rise == LEAD*BIT, "R3 carrier to first start", cs - c_rise, LEAD*BIT);
                chk(ch[0] == 1'b0, "R5 start bit", ch[0], 0);
                chk(ch[10] == 1'b1, "R5 stop bit", ch[10], 1);
                chk(ch[9] == ~(^ch[8:1]), "R5 odd parity", ch[9], ~(^ch[8:1]));
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected character", ch[8:1], -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(ch[8:1] == e, (frame_chars < PRE) ? "R4 preamble byte" : "R6 payload byte",
                        ch[8:1], e);
                end
                frame_chars++;
                last_end = cs + 11*BIT;
            end
        end
    end

    // driver: pushes expected characters, then feeds the host stream
    task automatic run_frame(input logic [7:0] b0, input logic [7:0] b1, input int n,
                             input int gap, input bit stray);
        for (int i = 0; i < PRE; i++) exp_q.push_back(8'hFF);
        exp_q.push_back(b0);
        if (n > 1) exp_q.push_back(b1);
        exp_chars = PRE + n;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(carrier_req_o == 1'b1, "R2 carrier after start", carrier_req_o, 1);
        chk(txd_o == 1'b1, "R2 mark at carrier on", txd_o, 1);
        repeat (LEAD*BIT + 3*BIT) @(negedge clk);
        chk(tx_ready_o == 1'b0, "R6 no ready in preamble", tx_ready_o, 0);
        if (stray) begin
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;   // R9 stray request
        end
        for (int i = 0; i < n; i++) begin
            if (i == 1 && gap > 0) begin
                while (!tx_ready_o) @(negedge clk);
                for (int j = 0; j < 4; j++) begin
                    repeat (gap/4) @(negedge clk);
                    chk(carrier_req_o && txd_o, "R7 mark with carrier during gap",
                        {carrier_req_o, txd_o}, 3);
                end
            end
            tx_data_i  = (i == 0) ? b0 : b1;
            tx_last_i  = (i == n-1);
            tx_valid_i = 1'b1;
            while (!tx_ready_o) @(negedge clk);
            @(negedge clk);
            tx_valid_i = 1'b0;
            tx_last_i  = 1'b0;
        end
        while (carrier_req_o) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all bytes sent", exp_q.size(), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(carrier_req_o == 1'b0, "R1 reset carrier", carrier_req_o, 0);
        chk(txd_o == 1'b1, "R1 reset line", txd_o, 1);
        chk(tx_ready_o == 1'b0, "R1 reset ready", tx_ready_o, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(carrier_req_o == 1'b0, "R2 idle without start", carrier_req_o, 0);
        run_frame(8'hA5, 8'h3C, 2, 0, 1'b0);
        run_frame(8'h80, 8'h01, 2, 2000, 1'b1);
        run_frame(8'h00, 8'h00, 1, 0, 1'b0);
        chk(ready_bad == 0, "R6 ready only at boundary", ready_bad, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        summary();
        $finish;
    end
endmodule